// File: doc/BRIEF.md
# DMA Channel Control, Request Detection and End-of-Transfer Logic

This block holds the control and status word of a single DMA channel together with its transfer counter, its request detector and its end-of-transfer logic. Software programs the channel through a small synchronous register port. One select bit chooses between the control word and the counter. The block qualifies the external request line and presents a single request-valid output to the bus master, which lies outside this block. It counts the completion pulses that the master returns. When the counter runs out it sets a sticky end flag and, if enabled, raises an interrupt. The address-mode and bus-mode bits are not used here. They are passed straight out to the address generator and the master.

The request line passes through a synchronizer. It is then read either as a level or as an edge, and a polarity bit picks which level or edge counts. In edge mode a detected edge is held pending until a completion pulse consumes it. An NMI or an address error stops the channel by clearing its enable. A global master-enable input also gates the request. None of these stops sets the end flag. The end flag can be cleared only by a read that returns it as 1 followed by a write of 0.

Top module: `dma_chan_ctl`

## Requirements
- R1: After `rst`, or after a cycle with `standby_i` high, every control field and the counter read as 0, and `req_valid_o`, `irq_o`, `burst_o` and `single_addr_o` are 0.
- R2: With `reg_sel_i`=0 the port reads and writes the control word. Its bit layout is: bit0 channel enable, bit1 end flag, bit2 interrupt enable, bit3 address mode (1 = single address, 0 = dual), bit4 bus mode (1 = burst, 0 = cycle steal), bit5 request polarity, bit6 edge select (1 = edge, 0 = level). `single_addr_o` follows bit3 and `burst_o` follows bit4. With `reg_sel_i`=1 the port accesses the counter.
- R3: In level mode a request is detected while the synchronized `dreq_i` equals the polarity bit: low when the bit is 0, high when it is 1. A change on `dreq_i` shows on `req_valid_o` by the third rising edge.
- R4: In edge mode a falling edge (polarity 0) or a rising edge (polarity 1) of the synchronized `dreq_i` is latched as pending. The pending request stays until an accepted `xfer_done_i` pulse consumes it. An edge of the other direction has no effect.
- R5: `req_valid_o` is high only when channel enable is 1, `master_en_i` is 1, the end flag is 0 and a request is detected.
- R6: An `xfer_done_i` pulse decrements the counter only while the channel is enabled, `master_en_i` is 1, the end flag is 0 and no abort is present. A pulse is ignored at any other time, and also when the counter is already 0.
- R7: The end flag sets when an accepted pulse takes the counter from 1 to 0, and at no other time.
- R8: An `nmi_i` or `addr_err_i` pulse clears channel enable and leaves the counter and the end flag unchanged. A stop caused by `master_en_i` low or by channel enable written to 0 does not set the end flag.
- R9: A write of 0 to the end flag clears it only if a control-word read since the last control write returned it as 1. Otherwise the flag stays set, and software can never set it.
- R10: While the end flag is 1, writing 1 to channel enable does not make `req_valid_o` assert.
- R11: `irq_o` is high while both the end flag and interrupt enable are 1, and is 0 whenever interrupt enable is 0.
- R12: While `mod_standby_i` is high, all state holds its value, register writes and completion pulses are ignored, and `req_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Standby entry; clears all state synchronously |
| mod_standby_i | input | 1 | Module standby; freezes all state |
| reg_sel_i | input | 1 | 0 selects the control word, 1 selects the counter |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data of the selected register |
| dreq_i | input | 1 | Asynchronous transfer request line |
| xfer_done_i | input | 1 | One pulse per completed transfer, from the bus master |
| nmi_i | input | 1 | Abort caused by a non-maskable interrupt |
| addr_err_i | input | 1 | Abort caused by an address error |
| master_en_i | input | 1 | Global enable for all DMA channels |
| req_valid_o | output | 1 | Qualified transfer request to the bus master |
| irq_o | output | 1 | End-of-transfer interrupt |
| burst_o | output | 1 | Bus mode: 1 = burst |
| single_addr_o | output | 1 | Address mode: 1 = single address |

## Verification
A wrong end flag shows at once. It appears on `irq_o` when interrupts are enabled and as a stuck-low `req_valid_o`, one edge after the completion pulse that should or should not have set it. A wrong counter value becomes visible on the next counter read. It also shows as an end flag that is early, late or missing at terminal count. A wrong pending-edge or synchronizer state appears on `req_valid_o` within three edges of the `dreq_i` change. A wrong read-arm state appears only at the following control write, which either clears the flag or fails to.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int CTRL_W = 7;

    // Control word; packed MSB first, so en is bit0 and edge_sel bit6.
    typedef struct packed {
        logic edge_sel;   // 1: edge sensing, 0: level sensing
        logic pol;        // 1: high / rising, 0: low / falling
        logic burst;      // 1: burst, 0: cycle steal
        logic single;     // 1: single address, 0: dual address
        logic ie;         // end interrupt enable
        logic te;         // transfer end flag
        logic en;         // channel enable
    } ctrl_t;

    typedef enum logic {
        SEL_CTRL  = 1'b0,
        SEL_COUNT = 1'b1
    } reg_sel_e;

    function automatic logic level_match(input logic s, input logic pol);
        return s == pol;
    endfunction

    function automatic logic edge_match(input logic cur, input logic prev,
                                        input logic pol);
        return pol ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/dmach_req_detect.sv
module dmach_req_detect
    import dmach_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic hold_i,
    input  logic dreq_i,
    input  logic edge_sel_i,
    input  logic pol_i,
    input  logic consume_i,
    output logic detect_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic                   pend_q;
    logic                   pend_n;
    logic                   s_cur;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            chain_q <= '0;
        end else if (!hold_i) begin
            chain_q[0] <= dreq_i;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign s_cur = chain_q[LAST];

    always_comb begin
        pend_n = 1'b0;
        if (edge_sel_i) begin
            pend_n = edge_match(s_cur, prev_q, pol_i) | (pend_q & ~consume_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (!hold_i) begin
            prev_q <= s_cur;
            pend_q <= pend_n;
        end
    end

    assign detect_o = edge_sel_i ? pend_q : level_match(s_cur, pol_i);

endmodule

// File: rtl/dmach_counter.sv
module dmach_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             hold_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o,
    output logic             terminal_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_n;

    always_comb begin
        count_n    = count_q;
        terminal_o = 1'b0;
        if (wr_i) begin
            count_n = wdata_i;
        end else if (step_i && (count_q != '0)) begin
            count_n    = count_q - ONE;
            terminal_o = (count_q == ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            count_q <= '0;
        end else if (!hold_i) begin
            count_q <= count_n;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/dmach_ctrl_reg.sv
module dmach_ctrl_reg
    import dmach_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_i,
    input  logic  hold_i,
    input  logic  wr_i,
    input  logic  rd_i,
    input  ctrl_t wdata_i,
    input  logic  abort_i,
    input  logic  set_te_i,
    output ctrl_t ctrl_o,
    output logic  armed_o
);
    ctrl_t ctrl_q, ctrl_n;
    logic  armed_q, armed_n;

    always_comb begin
        ctrl_n  = ctrl_q;
        armed_n = armed_q;
        if (rd_i && ctrl_q.te) begin
            armed_n = 1'b1;
        end
        if (wr_i) begin
            ctrl_n.en       = wdata_i.en;
            ctrl_n.ie       = wdata_i.ie;
            ctrl_n.single   = wdata_i.single;
            ctrl_n.burst    = wdata_i.burst;
            ctrl_n.pol      = wdata_i.pol;
            ctrl_n.edge_sel = wdata_i.edge_sel;
            if (armed_q && !wdata_i.te) begin
                ctrl_n.te = 1'b0;
            end
            armed_n = 1'b0;
        end
        if (abort_i) begin
            ctrl_n.en = 1'b0;
        end
        if (set_te_i) begin
            ctrl_n.te = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            ctrl_q  <= '0;
            armed_q <= 1'b0;
        end else if (!hold_i) begin
            ctrl_q  <= ctrl_n;
            armed_q <= armed_n;
        end
    end

    assign ctrl_o  = ctrl_q;
    assign armed_o = armed_q;

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dmach_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             standby_i,
    input  logic             mod_standby_i,
    input  logic             reg_sel_i,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    input  logic             dreq_i,
    input  logic             xfer_done_i,
    input  logic             nmi_i,
    input  logic             addr_err_i,
    input  logic             master_en_i,
    output logic             req_valid_o,
    output logic             irq_o,
    output logic             burst_o,
    output logic             single_addr_o
);
    localparam int PAD_W = CNT_W - CTRL_W;

    reg_sel_e         sel;
    ctrl_t            ctrl;
    logic             armed;
    logic [CNT_W-1:0] count;
    logic             terminal;
    logic             abort;
    logic             active;
    logic             step;
    logic             detect;
    logic             wr_ctrl, wr_cnt, rd_ctrl;

    assign sel     = reg_sel_e'(reg_sel_i);
    assign wr_ctrl = wr_en_i & (sel == SEL_CTRL);
    assign wr_cnt  = wr_en_i & (sel == SEL_COUNT);
    assign rd_ctrl = rd_en_i & (sel == SEL_CTRL);
    assign abort   = nmi_i | addr_err_i;
    assign active  = ctrl.en & master_en_i & ~ctrl.te & ~abort & ~mod_standby_i;
    assign step    = xfer_done_i & active;

    dmach_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (standby_i),
        .hold_i   (mod_standby_i),
        .wr_i     (wr_ctrl),
        .rd_i     (rd_ctrl),
        .wdata_i  (ctrl_t'(wdata_i[CTRL_W-1:0])),
        .abort_i  (abort),
        .set_te_i (terminal),
        .ctrl_o   (ctrl),
        .armed_o  (armed)
    );

    dmach_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (standby_i),
        .hold_i     (mod_standby_i),
        .wr_i       (wr_cnt),
        .wdata_i    (wdata_i),
        .step_i     (step),
        .count_o    (count),
        .terminal_o (terminal)
    );

    dmach_req_detect #(.SYNC_STAGES(SYNC_STAGES)) u_req (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (standby_i),
        .hold_i     (mod_standby_i),
        .dreq_i     (dreq_i),
        .edge_sel_i (ctrl.edge_sel),
        .pol_i      (ctrl.pol),
        .consume_i  (step),
        .detect_o   (detect)
    );

    assign rdata_o = (sel == SEL_COUNT) ? count : {{PAD_W{1'b0}}, ctrl};

    assign req_valid_o   = ctrl.en & master_en_i & ~ctrl.te & detect & ~mod_standby_i;
    assign irq_o         = ctrl.ie & ctrl.te;
    assign burst_o       = ctrl.burst;
    assign single_addr_o = ctrl.single;

endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             standby_i,
    input logic             mod_standby_i,
    input logic             reg_sel_i,
    input logic             wr_en_i,
    input logic             xfer_done_i,
    input logic             nmi_i,
    input logic             addr_err_i,
    input logic             master_en_i,
    input logic             req_valid_o,
    input logic             irq_o,
    input logic             en,
    input logic             te,
    input logic             ie,
    input logic             armed,
    input logic [CNT_W-1:0] count
);
    // R5
    req_gate_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> (en && !te && master_en_i));

    // R11
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (te && ie));

    // R8
    abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
        ((nmi_i || addr_err_i) && !mod_standby_i && !standby_i) |=> !en);

    // R7
    te_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(te) |-> $past(xfer_done_i && (count == CNT_W'(1)) && master_en_i
                            && !nmi_i && !addr_err_i && !mod_standby_i
                            && !(wr_en_i && reg_sel_i)));

    // R9
    te_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(te) |-> $past(standby_i || (armed && wr_en_i && !reg_sel_i
                                          && !mod_standby_i)));

    // R12
    hold_count_chk: assert property (@(posedge clk) disable iff (rst)
        (mod_standby_i && !standby_i) |=> $stable(count));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_done_i && en && master_en_i && !te && !nmi_i && !addr_err_i
         && !mod_standby_i && !standby_i && !(wr_en_i && reg_sel_i)
         && (count != '0))
        |=> (count == $past(count) - CNT_W'(1)));

endmodule

bind dma_chan_ctl dmach_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .standby_i     (standby_i),
    .mod_standby_i (mod_standby_i),
    .reg_sel_i     (reg_sel_i),
    .wr_en_i       (wr_en_i),
    .xfer_done_i   (xfer_done_i),
    .nmi_i         (nmi_i),
    .addr_err_i    (addr_err_i),
    .master_en_i   (master_en_i),
    .req_valid_o   (req_valid_o),
    .irq_o         (irq_o),
    .en            (ctrl.en),
    .te            (ctrl.te),
    .ie            (ctrl.ie),
    .armed         (armed),
    .count         (count)
);

// File: tb/sim_dma_chan_ctl.sv
`timescale 1ns/1ps
module sim_dma_chan_ctl;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst, standby, mstby, sel, wr, rd, dreq, done, nmi, aerr, men;
    logic [CNT_W-1:0] wdata, rdata;
    logic req_valid, irq, burst, single;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dma_chan_ctl #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .standby_i(standby), .mod_standby_i(mstby),
        .reg_sel_i(sel), .wr_en_i(wr), .rd_en_i(rd), .wdata_i(wdata),
        .rdata_o(rdata), .dreq_i(dreq), .xfer_done_i(done), .nmi_i(nmi),
        .addr_err_i(aerr), .master_en_i(men), .req_valid_o(req_valid),
        .irq_o(irq), .burst_o(burst), .single_addr_o(single)
    );

    // {edge_sel, pol, dreq_before, dreq_after, master_en, expected req_valid}
    localparam logic [5:0] VEC [0:9] = '{
        6'b00_10_1_1, 6'b00_01_1_0, 6'b01_01_1_1, 6'b01_10_1_0,
        6'b11_01_1_1, 6'b11_10_1_0, 6'b10_10_1_1, 6'b10_01_1_0,
        6'b01_01_0_0, 6'b10_10_0_0
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic d, input logic m);
        @(negedge clk);
        rst = 1; standby = 0; mstby = 0; sel = 0; wr = 0; rd = 0; wdata = '0;
        dreq = d; done = 0; nmi = 0; aerr = 0; men = m;
        ticks(3);
        rst = 0;
    endtask

    task automatic wreg(input logic s, input logic [CNT_W-1:0] v);
        @(negedge clk);
        sel = s; wdata = v; wr = 1;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic rreg(input logic s, output logic [CNT_W-1:0] v);
        @(negedge clk);
        sel = s; rd = 1;
        #1 v = rdata;
        @(negedge clk);
        rd = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk); done = 1;
        @(negedge clk); done = 0;
    endtask

    initial begin
        logic [CNT_W-1:0] v;

        // R1 reset state
        do_reset(0, 1);
        rreg(0, v); chk("R1 ctrl", v, 0);
        rreg(1, v); chk("R1 count", v, 0);
        chk("R1 outputs", {req_valid, irq, burst, single}, 0);

        // R3 R4 R5 vector walk
        for (int i = 0; i < 10; i++) begin
            do_reset(VEC[i][3], VEC[i][1]);
            ticks(4);
            wreg(0, CNT_W'({VEC[i][5], VEC[i][4], 5'b00001}));
            @(negedge clk); dreq = VEC[i][2];
            ticks(4);
            chk($sformatf("R3/R4/R5 vector %0d", i), req_valid, VEC[i][0]);
        end

        // R2 mode bits and layout
        do_reset(0, 1);
        wreg(0, 16'h0018);
        rreg(0, v); chk("R2 readback", v, 16'h0018);
        chk("R2 burst/single", {burst, single}, 2'b11);
        wreg(0, 16'h0010);
        chk("R2 burst only", {burst, single}, 2'b10);

        // R6 R7 R10 R9 R11 terminal count flow
        do_reset(1, 1);
        wreg(1, 16'd3);
        wreg(0, 16'h0025);
        ticks(3);
        chk("R5 active request", req_valid, 1);
        pulse_done(); rreg(1, v); chk("R6 dec 3->2", v, 2);
        pulse_done(); rreg(1, v); chk("R6 dec 2->1", v, 1);
        chk("R7 no early end", irq, 0);
        pulse_done(); rreg(1, v); chk("R6 dec 1->0", v, 0);
        chk("R11 irq at end", irq, 1);
        chk("R7 request stops", req_valid, 0);
        wreg(0, 16'h0025);
        chk("R9 zero write without read keeps flag", irq, 1);
        chk("R10 enable while end flag", req_valid, 0);
        rreg(0, v); chk("R7 end flag read", v, 16'h0027);
        wreg(0, 16'h0025);
        rreg(0, v); chk("R9 cleared after read", v, 16'h0025);
        chk("R11 irq cleared", irq, 0);
        ticks(1);
        chk("R9 request resumes", req_valid, 1);
        pulse_done(); rreg(1, v); chk("R6 ignore at zero", v, 0);
        rreg(0, v); chk("R7 no end at zero", v, 16'h0025);

        // R11 interrupt disabled
        do_reset(1, 1);
        wreg(1, 16'd1); wreg(0, 16'h0021);
        pulse_done();
        chk("R11 irq masked", irq, 0);
        rreg(0, v); chk("R7 end flag set", v, 16'h0023);
        wreg(0, 16'h0021);
        rreg(0, v); chk("R9 armed clear", v, 16'h0021);

        // R8 aborts
        do_reset(1, 1);
        wreg(1, 16'd5); wreg(0, 16'h0021);
        @(negedge clk); nmi = 1; @(negedge clk); nmi = 0;
        rreg(0, v); chk("R8 nmi clears enable", v, 16'h0020);
        pulse_done(); rreg(1, v); chk("R8 count kept after nmi", v, 5);
        wreg(0, 16'h0021);
        @(negedge clk); aerr = 1; @(negedge clk); aerr = 0;
        rreg(0, v); chk("R8 addr error clears enable", v, 16'h0020);
        wreg(0, 16'h0021); wreg(1, 16'd1);
        @(negedge clk); men = 0;
        pulse_done(); rreg(1, v); chk("R6 master off ignored", v, 1);
        chk("R5 master off", req_valid, 0);
        rreg(0, v); chk("R8 master off no end", v, 16'h0021);
        @(negedge clk); men = 1;
        wreg(0, 16'h0020);
        pulse_done(); rreg(1, v); chk("R8 disabled no count", v, 1);
        rreg(0, v); chk("R8 disabled no end", v, 16'h0020);

        // R4 edge consumed by completion
        do_reset(0, 1);
        wreg(1, 16'd4); ticks(4);
        wreg(0, 16'h0061);
        @(negedge clk); dreq = 1; ticks(4);
        chk("R4 rising edge latched", req_valid, 1);
        ticks(3);
        chk("R4 pending holds", req_valid, 1);
        pulse_done();
        chk("R4 consumed", req_valid, 0);
        rreg(1, v); chk("R6 edge count", v, 3);

        // R12 module standby
        do_reset(1, 1);
        wreg(0, 16'h0039); wreg(1, 16'd7); ticks(3);
        @(negedge clk); mstby = 1;
        #1 chk("R12 request off", req_valid, 0);
        wreg(0, 16'h0001); wreg(1, 16'd2); pulse_done();
        @(negedge clk); mstby = 0;
        rreg(0, v); chk("R12 ctrl held", v, 16'h0039);
        rreg(1, v); chk("R12 count held", v, 7);

        // R1 standby entry
        @(negedge clk); standby = 1; @(negedge clk); standby = 0;
        rreg(0, v); chk("R1 standby ctrl", v, 0);
        rreg(1, v); chk("R1 standby count", v, 0);
        chk("R1 standby outputs", {req_valid, irq, burst, single}, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule